// File: doc/BRIEF.md
# SDRAM Size Probe Engine

This block is a hardware sequencer that finds how much SDRAM is fitted behind a memory controller. It tests for address aliasing: when a chip is smaller than the space the controller decodes, a write to word 0 shows up again at an offset equal to the chip size. The engine walks candidate offsets, proves or rules out aliasing at each, and then checks whether a second bank responds at all. It works through a simple single-beat memory master port with request and acknowledge signals.

A start pulse launches a probe. Before the first access the engine drops a control line that turns off the controller's write buffering, so that a test write reaches the chip before the check read. It raises the line again when it finishes. Inputs give the largest bank size the controller is set for, whether the second bank is switched on, and an optional board-declared size. Outputs give the first-bank size, the total size, a flag for two populated banks, and a one-cycle completion pulse. Every word the probe overwrites is written back with its original value.

Top module: `mirror_size_probe`

## Requirements
- R1: Out of reset and while idle, `bufEnable` is 1, `done` is 0 and `memReq` is 0.
- R2: Candidate offsets start at 2 MiB and double while the candidate is no larger than half of `maxSize`. When no candidate aliases, `bankSize` equals `maxSize`. When `maxSize` is 2 MiB, the first bank is settled with no memory access at all.
- R3: At each candidate the engine reads word 0 and the word at the candidate offset. If the two differ, it makes no write for that candidate and moves on.
- R4: The test write puts 0x55555555 at the base. If the word read at the offset already equals 0x55555555, the test write puts 0xAAAAAAAA there instead.
- R5: Between completion of the test write and the request of the check read, `memReq` stays low for at least `SETTLE_CYCLES` cycles.
- R6: After each test write, the word first read from the base is written back to the base. When the probe ends, memory holds its original contents.
- R7: The first candidate whose check read returns the test pattern becomes `bankSize`.
- R8: The second bank is probed only when `bankSize` equals `maxSize` and `bank2En` is 1. Its word at byte address `maxSize + bankSize - 4` is tested against itself. Success makes the detected total twice `bankSize`. No access at or above `maxSize` happens otherwise.
- R9: `bufEnable` falls on start and is 0 during every memory request. It returns to 1 on every exit path.
- R10: `done` is a one-cycle pulse during which `bufEnable` is 1 and the size outputs are valid.
- R11: When `boardSize` is nonzero and differs from the detected total, `totalSize` reports `boardSize`. Otherwise `totalSize` reports the detected total.
- R12: `twoBanks` is 1 exactly when the detected total, before any override, exceeds `bankSize`.
- R13: Once raised, `memReq` holds `memAddr`, `memWe` and `memWdata` stable until `memAck`. Each acknowledged cycle completes one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a probe (ignored while busy) |
| maxSize | input | ADDR_W+1 | Largest bank size the controller decodes, bytes, power of two |
| bank2En | input | 1 | Second bank switched on in the controller |
| boardSize | input | ADDR_W+1 | Board-declared total size in bytes, 0 for none |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | ADDR_W | Byte address of the access |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, valid with memAck |
| memAck | input | 1 | Access complete |
| bufEnable | output | 1 | 1 lets the controller buffer writes |
| bankSize | output | ADDR_W+1 | Detected first-bank size in bytes |
| totalSize | output | ADDR_W+1 | Reported total size in bytes |
| twoBanks | output | 1 | Second bank found populated |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two decisions resolve in the same finish cycle: whether the second-bank test added to the total, and whether the board-declared size replaces that total. The bench provokes both at once by fitting a populated second bank and also giving a nonzero board size. It then checks that `totalSize` follows the board value while `twoBanks` still reflects the detected two-bank total. Runs with a board value equal to the detected total, and with a board value below a single bank, check that the override and the flag stay independent in both directions.

// File: rtl/probe_pkg.sv
package probe_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_NEXT,
    S_RD_BASE,
    S_RD_OFS,
    S_CMP,
    S_WR_PAT,
    S_SETTLE,
    S_RD_CHK,
    S_RESTORE,
    S_EVAL,
    S_FINISH,
    S_DONE
  } probeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic init;
    logic capSaved;
    logic capOffs;
    logic capCheck;
    logic settleLoad;
    logic advance;
    logic lockBank;
    logic openBank2;
    logic addBank2;
    logic finish;
    logic addrProbe;
    logic wrRestore;
  } dpStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic wordsEqual;
    logic patternSeen;
    logic candInRange;
    logic bank2Eligible;
    logic settleDone;
    logic inBank2;
  } dpStatus_t;

endpackage

// File: rtl/probe_ctrl.sv
module probe_ctrl
  import probe_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      memAck,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      memReq,
  output logic      memWe,
  output logic      bufEnable,
  output logic      done
);

  probeState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bufEnable <= 1'b1;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && start) bufEnable <= 1'b0;
      else if (state == S_FINISH)   bufEnable <= 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    done      = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strobe.init = 1'b1;
          stateNext   = S_NEXT;
        end
      end
      S_NEXT: begin
        if (status.candInRange) begin
          stateNext = S_RD_BASE;
        end else begin
          strobe.lockBank = 1'b1;
          stateNext       = S_EVAL;
        end
      end
      S_RD_BASE: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.capSaved = 1'b1;
          stateNext       = S_RD_OFS;
        end
      end
      S_RD_OFS: begin
        memReq           = 1'b1;
        strobe.addrProbe = 1'b1;
        if (memAck) begin
          strobe.capOffs = 1'b1;
          stateNext      = S_CMP;
        end
      end
      S_CMP: begin
        if (status.wordsEqual) begin
          stateNext = S_WR_PAT;
        end else if (status.inBank2) begin
          stateNext = S_FINISH;
        end else begin
          strobe.advance = 1'b1;
          stateNext      = S_NEXT;
        end
      end
      S_WR_PAT: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          strobe.settleLoad = 1'b1;
          stateNext         = S_SETTLE;
        end
      end
      S_SETTLE: begin
        if (status.settleDone) stateNext = S_RD_CHK;
      end
      S_RD_CHK: begin
        memReq           = 1'b1;
        strobe.addrProbe = 1'b1;
        if (memAck) begin
          strobe.capCheck = 1'b1;
          stateNext       = S_RESTORE;
        end
      end
      S_RESTORE: begin
        memReq           = 1'b1;
        memWe            = 1'b1;
        strobe.wrRestore = 1'b1;
        if (memAck) begin
          if (status.inBank2) begin
            strobe.addBank2 = status.patternSeen;
            stateNext       = S_FINISH;
          end else if (status.patternSeen) begin
            strobe.lockBank = 1'b1;
            stateNext       = S_EVAL;
          end else begin
            strobe.advance = 1'b1;
            stateNext      = S_NEXT;
          end
        end
      end
      S_EVAL: begin
        if (status.bank2Eligible) begin
          strobe.openBank2 = 1'b1;
          stateNext        = S_RD_BASE;
        end else begin
          stateNext = S_FINISH;
        end
      end
      S_FINISH: begin
        strobe.finish = 1'b1;
        stateNext     = S_DONE;
      end
      S_DONE: begin
        done      = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/probe_dp.sv
module probe_dp
  import probe_pkg::*;
#(
  parameter int ADDR_W        = 28,
  parameter int DATA_W        = 32,
  parameter int MIN_LOG2      = 21,
  parameter int SETTLE_CYCLES = 500
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W:0]   maxSize,
  input  logic              bank2En,
  input  logic [ADDR_W:0]   boardSize,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W:0]   bankSize,
  output logic [ADDR_W:0]   totalSize,
  output logic              twoBanks,
  output dpStatus_t         status
);

  localparam int SIZE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SIZE_W-1:0] MIN_CAND = SIZE_W'(1) << MIN_LOG2;
  localparam logic [DATA_W-1:0] PAT_LO   = {(DATA_W/2){2'b01}};
  localparam logic [DATA_W-1:0] PAT_HI   = {(DATA_W/2){2'b10}};
  localparam logic [SIZE_W-1:0] WORD_B   = SIZE_W'(DATA_W / 8);

  logic [SIZE_W-1:0] cand;
  logic [SIZE_W-1:0] detTotal;
  logic [DATA_W-1:0] savedWord, offsWord, checkWord, pattern;
  logic [CNT_W-1:0]  settleCnt;
  logic              phase2;
  logic [SIZE_W-1:0] probeBase, probeOfs, probeAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cand      <= MIN_CAND;
      phase2    <= 1'b0;
      bankSize  <= '0;
      detTotal  <= '0;
      totalSize <= '0;
      twoBanks  <= 1'b0;
      savedWord <= '0;
      offsWord  <= '0;
      checkWord <= '0;
      pattern   <= PAT_LO;
      settleCnt <= '0;
    end else begin
      if (strobe.init) begin
        cand     <= MIN_CAND;
        phase2   <= 1'b0;
        bankSize <= '0;
        detTotal <= '0;
      end
      if (strobe.advance)   cand      <= cand << 1;
      if (strobe.capSaved)  savedWord <= memRdata;
      if (strobe.capOffs) begin
        offsWord <= memRdata;
        pattern  <= (memRdata == PAT_LO) ? PAT_HI : PAT_LO;
      end
      if (strobe.capCheck)  checkWord <= memRdata;
      if (strobe.lockBank) begin
        bankSize <= cand;
        detTotal <= cand;
      end
      if (strobe.openBank2) phase2   <= 1'b1;
      if (strobe.addBank2)  detTotal <= detTotal + bankSize;
      if (strobe.finish) begin
        totalSize <= (boardSize != '0 && boardSize != detTotal) ? boardSize : detTotal;
        twoBanks  <= (detTotal > bankSize);
      end
      if (strobe.settleLoad)     settleCnt <= CNT_W'(SETTLE_CYCLES - 1);
      else if (settleCnt != '0)  settleCnt <= settleCnt - 1'b1;
    end
  end

  // first bank: base 0, offset = candidate; second bank: top word, offset 0
  assign probeBase = phase2 ? (maxSize + bankSize - WORD_B) : '0;
  assign probeOfs  = phase2 ? '0 : cand;
  assign probeAddr = probeBase + (strobe.addrProbe ? probeOfs : '0);
  assign memAddr   = probeAddr[ADDR_W-1:0];
  assign memWdata  = strobe.wrRestore ? savedWord : pattern;

  assign status.wordsEqual    = (savedWord == offsWord);
  assign status.patternSeen   = (checkWord == pattern);
  assign status.candInRange   = (cand <= (maxSize >> 1));
  assign status.bank2Eligible = bank2En && (bankSize == maxSize);
  assign status.settleDone    = (settleCnt == '0);
  assign status.inBank2       = phase2;

endmodule

// File: rtl/mirror_size_probe.sv
module mirror_size_probe
  import probe_pkg::*;
#(
  parameter int ADDR_W        = 28,
  parameter int DATA_W        = 32,
  parameter int MIN_LOG2      = 21,
  parameter int SETTLE_CYCLES = 500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W:0]   maxSize,
  input  logic              bank2En,
  input  logic [ADDR_W:0]   boardSize,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic              bufEnable,
  output logic [ADDR_W:0]   bankSize,
  output logic [ADDR_W:0]   totalSize,
  output logic              twoBanks,
  output logic              done
);

  dpStrobe_t strobe;
  dpStatus_t status;

  probe_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .memAck    (memAck),
    .status    (status),
    .strobe    (strobe),
    .memReq    (memReq),
    .memWe     (memWe),
    .bufEnable (bufEnable),
    .done      (done)
  );

  probe_dp #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .MIN_LOG2      (MIN_LOG2),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .maxSize   (maxSize),
    .bank2En   (bank2En),
    .boardSize (boardSize),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .bankSize  (bankSize),
    .totalSize (totalSize),
    .twoBanks  (twoBanks),
    .status    (status)
  );

endmodule

// File: rtl/probe_checker.sv
module probe_checker #(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W:0]   maxSize,
  input logic              bank2En,
  input logic [ADDR_W:0]   boardSize,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memAck,
  input logic              bufEnable,
  input logic [ADDR_W:0]   totalSize,
  input logic              done
);

  // R13: request held with stable address and data until acknowledged
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  // R9: no access while the controller buffers writes
  assert_buf_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !bufEnable);

  // R10: completion is a single cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: buffers are back on when completion is flagged
  assert_done_buf_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> bufEnable);

  // R8: no access above the first bank unless the second bank is on
  assert_bank2_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && ({1'b0, memAddr} >= maxSize) |-> bank2En);

  // R11: a nonzero board size is what gets reported
  assert_board_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    done && (boardSize != '0) |-> totalSize == boardSize);

endmodule

bind mirror_size_probe probe_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .maxSize   (maxSize),
  .bank2En   (bank2En),
  .boardSize (boardSize),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .memWdata  (memWdata),
  .memAck    (memAck),
  .bufEnable (bufEnable),
  .totalSize (totalSize),
  .done      (done)
);

// File: tb/sim_mirror_size_probe.sv
`timescale 1ns/1ps
module sim_mirror_size_probe;

  localparam int ADDR_W = 28;
  localparam int DATA_W = 32;
  localparam int SETTLE = 12;
  localparam int MIB    = 1 << 20;
  localparam logic [31:0] PAT_LO = 32'h5555_5555;
  localparam logic [31:0] PAT_HI = 32'hAAAA_AAAA;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W:0]   maxSize = '0;
  logic              bank2En = 1'b0;
  logic [ADDR_W:0]   boardSize = '0;
  logic              memReq, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic [DATA_W-1:0] memRdata = '0;
  logic              memAck = 1'b0;
  logic              bufEnable, twoBanks, done;
  logic [ADDR_W:0]   bankSize, totalSize;

  mirror_size_probe #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .MIN_LOG2 (21), .SETTLE_CYCLES (SETTLE)
  ) u0 (
    .clk (clk), .rstN (rstN), .start (start), .maxSize (maxSize), .bank2En (bank2En),
    .boardSize (boardSize), .memReq (memReq), .memWe (memWe), .memAddr (memAddr),
    .memWdata (memWdata), .memRdata (memRdata), .memAck (memAck), .bufEnable (bufEnable),
    .bankSize (bankSize), .totalSize (totalSize), .twoBanks (twoBanks), .done (done)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // memory model: bank 1 aliases every phys1 bytes; bank 2 optional
  int unsigned phys1 = 8 * MIB;
  bit          present2 = 1'b0;
  logic [31:0] store [longint];

  function automatic longint mapAddr(input int unsigned a);
    if (a < int'(maxSize)) return longint'((a % phys1) >> 2);
    if (present2) return 64'h4000_0000 + longint'(((a - int'(maxSize)) % phys1) >> 2);
    return -1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAck <= 1'b0;
    end else if (memReq && !memAck) begin
      longint k;
      k = mapAddr(int'(memAddr));
      memAck <= 1'b1;
      if (memWe) begin
        if (k >= 0) store[k] = memWdata;
      end else begin
        memRdata <= (k < 0) ? 32'hFFFF_FFFF : (store.exists(k) ? store[k] : 32'h0);
      end
    end else begin
      memAck <= 1'b0;
    end
  end

  // port monitors
  int          wrCount, reqCount, bufViol, doneCount, gapCnt, minGap;
  bit          gapRun, measureGap, seenTop, highSeen;
  logic [31:0] firstWr;
  bit          firstSet;

  always @(negedge clk) begin
    cycles++;
    if (done) doneCount++;
    if (memReq && bufEnable) bufViol++;
    if (memReq && memAck) begin
      reqCount++;
      if ({1'b0, memAddr} >= maxSize) highSeen = 1'b1;
      if (memWe) begin
        wrCount++;
        if (!firstSet) begin firstWr = memWdata; firstSet = 1'b1; end
        if ({1'b0, memAddr} == maxSize + maxSize - 4) seenTop = 1'b1;
        if (measureGap && (memWdata == PAT_LO || memWdata == PAT_HI)) begin
          gapRun = 1'b1;
          gapCnt = 0;
        end
      end
    end else if (gapRun) begin
      if (memReq) begin
        if (gapCnt < minGap) minGap = gapCnt;
        gapRun = 1'b0;
      end else begin
        gapCnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one probe run; returns when done is seen (sampled at negedge)
  task automatic runProbe(input int maxB, input bit b2, input int board);
    int waitCnt;
    @(negedge clk);
    maxSize = (ADDR_W+1)'(maxB);
    bank2En = b2;
    boardSize = (ADDR_W+1)'(board);
    wrCount = 0; reqCount = 0; bufViol = 0; doneCount = 0;
    gapRun = 0; minGap = 1 << 30; seenTop = 0; highSeen = 0; firstSet = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!bufEnable, "R9", "bufEnable after start", bufEnable, 0);
    waitCnt = 0;
    while (!done && waitCnt < 20000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(done == 1'b1, "R10", "done reached", done, 1);
    check(bufEnable, "R9", "bufEnable at done", bufEnable, 1);
  endtask

  task automatic afterDone();
    @(negedge clk);
    check(!done, "R10", "done single cycle", done, 0);
    check(doneCount == 1, "R10", "done pulse count", doneCount, 1);
    check(bufViol == 0, "R9", "requests with buffers on", bufViol, 0);
  endtask

  task automatic testReset();
    check(bufEnable == 1'b1, "R1", "bufEnable in reset", bufEnable, 1);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(memReq == 1'b0, "R1", "memReq in reset", memReq, 0);
  endtask

  task automatic testSmallChip();  // R7: first alias at 2 MiB
    store.delete(); phys1 = 2 * MIB; present2 = 1;
    runProbe(8 * MIB, 1'b1, 0);
    check(bankSize == 2 * MIB, "R7", "bank at 2MiB", bankSize, 2 * MIB);
    check(totalSize == 2 * MIB, "R8", "total small chip", totalSize, 2 * MIB);
    check(!twoBanks, "R12", "twoBanks small chip", twoBanks, 0);
    check(!highSeen, "R8", "no access above bank 1", highSeen, 0);
    afterDone();
  endtask

  task automatic testMidChip();  // R3, R5, R6, R7
    store.delete(); phys1 = 4 * MIB; present2 = 0;
    store[0] = 32'hCAFE_F00D;
    measureGap = 1;
    runProbe(8 * MIB, 1'b0, 0);
    measureGap = 0;
    check(bankSize == 4 * MIB, "R7", "bank at 4MiB", bankSize, 4 * MIB);
    check(wrCount == 2, "R3", "writes with 2MiB mismatch", wrCount, 2);
    check(minGap >= SETTLE && minGap < (1 << 30), "R5", "settle gap", minGap, SETTLE);
    check(store[0] == 32'hCAFE_F00D, "R6", "word 0 restored", store[0], 32'hCAFE_F00D);
    afterDone();
  endtask

  task automatic testFullChip();  // R2: no alias found
    store.delete(); phys1 = 8 * MIB; present2 = 1;
    runProbe(8 * MIB, 1'b0, 0);
    check(bankSize == 8 * MIB, "R2", "bank equals max", bankSize, 8 * MIB);
    check(wrCount == 4, "R2", "two candidates tested", wrCount, 4);
    check(totalSize == 8 * MIB, "R8", "bank2 disabled total", totalSize, 8 * MIB);
    check(!highSeen, "R8", "bank2 disabled no high access", highSeen, 0);
    afterDone();
  endtask

  task automatic testBank2Present();
    store.delete(); phys1 = 8 * MIB; present2 = 1;
    runProbe(8 * MIB, 1'b1, 0);
    check(totalSize == 16 * MIB, "R8", "two bank total", totalSize, 16 * MIB);
    check(seenTop, "R8", "top word probed", seenTop, 1);
    check(twoBanks, "R12", "twoBanks set", twoBanks, 1);
    afterDone();
  endtask

  task automatic testBank2Absent();
    store.delete(); phys1 = 8 * MIB; present2 = 0;
    runProbe(8 * MIB, 1'b1, 0);
    check(totalSize == 8 * MIB, "R8", "absent bank2 total", totalSize, 8 * MIB);
    check(!twoBanks, "R12", "twoBanks clear", twoBanks, 0);
    afterDone();
  endtask

  task automatic testOverride();  // R11 with R12 in the same finish cycle
    store.delete(); phys1 = 8 * MIB; present2 = 1;
    runProbe(8 * MIB, 1'b1, 32 * MIB);
    check(totalSize == 32 * MIB, "R11", "board overrides", totalSize, 32 * MIB);
    check(twoBanks, "R12", "twoBanks from detection", twoBanks, 1);
    check(bankSize == 8 * MIB, "R11", "bank unaffected", bankSize, 8 * MIB);
    afterDone();
    store.delete();
    runProbe(8 * MIB, 1'b1, 16 * MIB);
    check(totalSize == 16 * MIB, "R11", "board equal", totalSize, 16 * MIB);
    afterDone();
    store.delete(); present2 = 0;
    runProbe(8 * MIB, 1'b0, 4 * MIB);
    check(totalSize == 4 * MIB, "R11", "board smaller", totalSize, 4 * MIB);
    check(!twoBanks, "R12", "twoBanks with small board", twoBanks, 0);
    afterDone();
  endtask

  task automatic testAltPattern();  // R4, R6
    store.delete(); phys1 = 2 * MIB; present2 = 0;
    store[0] = PAT_LO;
    runProbe(8 * MIB, 1'b0, 0);
    check(firstWr == PAT_HI, "R4", "alternate pattern", firstWr, PAT_HI);
    check(bankSize == 2 * MIB, "R7", "bank with alt pattern", bankSize, 2 * MIB);
    check(store[0] == PAT_LO, "R6", "word 0 restored", store[0], PAT_LO);
    afterDone();
    store.delete();
    runProbe(8 * MIB, 1'b0, 0);
    check(firstWr == PAT_LO, "R4", "primary pattern", firstWr, PAT_LO);
    afterDone();
  endtask

  task automatic testNoWrite();  // R3: all comparisons differ
    store.delete(); phys1 = 8 * MIB; present2 = 0;
    store[0] = 32'h0000_1234;
    runProbe(8 * MIB, 1'b0, 0);
    check(wrCount == 0, "R3", "no writes when words differ", wrCount, 0);
    check(bankSize == 8 * MIB, "R2", "bank max after mismatches", bankSize, 8 * MIB);
    afterDone();
  endtask

  task automatic testMinMax();  // R2: max 2 MiB, loop never runs
    store.delete(); phys1 = 2 * MIB; present2 = 0;
    runProbe(2 * MIB, 1'b0, 0);
    check(reqCount == 0, "R2", "no accesses at min max", reqCount, 0);
    check(bankSize == 2 * MIB, "R2", "bank at min max", bankSize, 2 * MIB);
    afterDone();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(bufEnable && !memReq && !done, "R1", "idle after reset", {bufEnable, memReq, done}, 3'b100);
    testSmallChip();
    testMidChip();
    testFullChip();
    testBank2Present();
    testBank2Absent();
    testOverride();
    testAltPattern();
    testNoWrite();
    testMinMax();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule